// File: doc/BRIEF.md
# 1-Wire Bus Master Slot and Reset Engine

This block drives a 1-Wire bus through an open-drain pull-down enable and turns single host commands into timed bus activity. It can issue a reset with presence detection, a single write slot, a single read slot, a whole byte written as eight write slots, or a whole byte read as eight read slots. Bytes go out and come in least-significant bit first. The bus level comes back on `line_in` and passes through a two-flop synchroniser before it is sampled.

All slot timing is counted in microseconds. The microsecond is derived from the system clock by `TICKS_PER_US`, and every interval is stretched by the integer `DELAY_SCALE`. A host may also arm a one-shot strong pull-up with a duration. The next byte write turns it on ahead of its last bit. It then holds it for the duration after the byte, and then clears the request.

Top module: `onewire_master`

## Requirements
- R1: After reset, `drive_low`, `strong_pu`, `busy` and `done` are all low.
- R2: A write-bit command with `cmd_data[0]`=1 pulls the line low for 6 µs and then releases it, and the slot lasts 70 µs in total.
- R3: A write-bit command with `cmd_data[0]`=0 pulls the line low for 60 µs and then releases it, and the slot lasts 70 µs in total.
- R4: A read-bit command pulls the line low for 6 µs and samples the line 9 µs after release, so a device holding the line low over that point yields `rsp_bit`=0. The slot lasts 70 µs.
- R5: A reset command pulls the line low for 500 µs and samples the line 70 µs after release. It then waits 430 µs before finishing. `rsp_bit` is 0 when a device answered with presence and 1 when none did.
- R6: A write-byte command sends `cmd_data` as eight back-to-back write slots, bit 0 first, each slot shaped as in R2/R3.
- R7: A read-byte command makes eight read slots, and `rsp_byte` holds the sampled bits with the first slot in bit 0.
- R8: Opcodes on `cmd_op` are 0 reset, 1 write bit, 2 read bit, 3 write byte and 4 read byte. A command is taken only when `busy` is low and the opcode is 0 to 4. Values 5 to 7, and any command offered while `busy` is high, cause no bus activity and no `done`.
- R9: `busy` is high from the cycle after a command is taken until its last interval ends. `done` pulses for exactly one cycle, in the first cycle with `busy` low.
- R10: A pull-up request armed with a nonzero `pu_dur` makes the next write-byte command assert `strong_pu` from the release point of its eighth slot. It holds `strong_pu` for `pu_dur` µs after that slot, and only then gives `done`. `strong_pu` is never high while `drive_low` is high.
- R11: The pull-up request is used once. It is cleared by the byte write that uses it or by arming it with `pu_dur`=0. Reset, bit and read-byte commands leave it pending.
- R12: Every interval in R2 to R10 lasts its microsecond count times `TICKS_PER_US` times `DELAY_SCALE` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command opcode (see R8) |
| cmd_data | input | 8 | Bit (bit 0) or byte to write |
| pu_arm | input | 1 | Load pull-up request when idle |
| pu_dur | input | PUD_W | Pull-up hold time in µs; 0 cancels |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_bit | output | 1 | Last sampled level: read bit or presence status |
| rsp_byte | output | 8 | Byte assembled by the last read-byte command |
| line_in | input | 1 | Bus level from the pad |
| drive_low | output | 1 | Open-drain pull-down enable |
| strong_pu | output | 1 | Strong pull-up enable |

## Verification
The assertions assume the host only loads a pull-up request or a command through the documented handshake. They also assume that `line_in` is the wired-AND of `drive_low` and any device pulls, so the line never reads low when nobody pulls it. The bench models the bus as that wired-AND. Its device model pulls the line only in short windows around the expected sample points, and only after a slot or reset begins. It offers commands while busy only through dedicated injection cycles, and it arms the pull-up only between commands, so every input stays inside those assumptions.

// File: rtl/owm_pkg.sv
package owm_pkg;

  localparam int SLOT_US_W = 10;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SK_W0,
    SK_W1,
    SK_RD,
    SK_RST
  } slot_kind_e;

  // Each slot is three phases: pulled low, released until the sample
  // point, then released until the slot ends.
  typedef struct packed {
    logic [SLOT_US_W-1:0] low_us;
    logic [SLOT_US_W-1:0] pre_us;
    logic [SLOT_US_W-1:0] post_us;
  } slot_time_t;

  function automatic slot_time_t slot_time(slot_kind_e k);
    slot_time_t t;
    case (k)
      SK_W0:        t = '{low_us: SLOT_US_W'(60),  pre_us: SLOT_US_W'(9),  post_us: SLOT_US_W'(1)};
      SK_W1, SK_RD: t = '{low_us: SLOT_US_W'(6),   pre_us: SLOT_US_W'(9),  post_us: SLOT_US_W'(55)};
      default:      t = '{low_us: SLOT_US_W'(500), pre_us: SLOT_US_W'(70), post_us: SLOT_US_W'(430)};
    endcase
    return t;
  endfunction

  function automatic slot_kind_e kind_of(op_e op, logic b);
    slot_kind_e k;
    case (op)
      OP_RESET:         k = SK_RST;
      OP_RBIT, OP_RBYTE: k = SK_RD;
      default:          k = b ? SK_W1 : SK_W0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (run)  cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/owm_slot.sv
module owm_slot
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       line_s,
  output logic       drive_low,
  output logic       sample_vld,
  output logic       sample_bit,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_PRE, S_POST} st_e;

  st_e                  st_q, st_d;
  logic [SLOT_US_W-1:0] us_q, us_d;
  slot_time_t           tm_q, tm_d;
  logic [SLOT_US_W-1:0] len;
  logic                 last;

  always_comb begin
    case (st_q)
      S_LOW:   len = tm_q.low_us;
      S_PRE:   len = tm_q.pre_us;
      default: len = tm_q.post_us;
    endcase
  end

  assign last       = tick && (us_q == len - 1'b1);
  assign sample_bit = line_s;
  assign drive_low  = (st_q == S_LOW);

  always_comb begin
    st_d       = st_q;
    us_d       = us_q;
    tm_d       = tm_q;
    done       = 1'b0;
    sample_vld = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d = S_LOW;
          us_d = '0;
          tm_d = slot_time(kind);
        end
      end
      S_LOW, S_PRE: begin
        if (last) begin
          st_d       = (st_q == S_LOW) ? S_PRE : S_POST;
          us_d       = '0;
          sample_vld = (st_q == S_PRE);
        end else if (tick) begin
          us_d = us_q + 1'b1;
        end
      end
      default: begin
        if (last) begin
          done = 1'b1;
          us_d = '0;
          if (start) begin
            st_d = S_LOW;
            tm_d = slot_time(kind);
          end else begin
            st_d = S_IDLE;
          end
        end else if (tick) begin
          us_d = us_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      us_q <= '0;
      tm_q <= '0;
    end else begin
      st_q <= st_d;
      us_q <= us_d;
      tm_q <= tm_d;
    end
  end

  // A slot only begins low after the sequencer asked for it.
  p_low_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(start));

  // The sample point never falls inside the pulled-low phase.
  p_sample_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> !drive_low);
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int PUD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             pu_arm,
  input  logic [PUD_W-1:0] pu_dur,
  input  logic             slot_done,
  input  logic             sample_vld,
  input  logic             sample_bit,
  input  logic             drive_low,
  output logic             slot_start,
  output slot_kind_e       slot_kind,
  output logic             tick_clr,
  output logic             busy,
  output logic             done,
  output logic             rsp_bit,
  output logic [7:0]       rsp_byte,
  output logic             strong_pu
);
  typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_HOLD} st_e;

  st_e              st_q, st_d;
  op_e              op_q, op_d;
  logic [7:0]       wsh_q, wsh_d;
  logic [2:0]       bit_q, bit_d;
  logic [PUD_W-1:0] dur_q, dur_d;
  logic [PUD_W-1:0] hold_q, hold_d;
  logic             pu_on_q, pu_on_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             rbit_q, rbit_d;
  logic [7:0]       rbyte_q, rbyte_d;
  logic             accept, is_byte, more;

  assign accept   = (st_q == Q_IDLE) && cmd_valid && (cmd_op <= 3'd4);
  assign is_byte  = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);
  assign more     = is_byte && (bit_q != 3'd7);
  assign tick_clr = accept;

  always_comb begin
    st_d       = st_q;
    op_d       = op_q;
    wsh_d      = wsh_q;
    bit_d      = bit_q;
    dur_d      = dur_q;
    hold_d     = hold_q;
    pu_on_d    = pu_on_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    rbit_d     = rbit_q;
    rbyte_d    = rbyte_q;
    slot_start = 1'b0;
    slot_kind  = SK_W1;

    if ((st_q == Q_IDLE) && pu_arm) dur_d = pu_dur;

    if (sample_vld) begin
      rbit_d = sample_bit;
      if (op_q == OP_RBYTE) rbyte_d = {sample_bit, rbyte_q[7:1]};
    end

    case (st_q)
      Q_IDLE: begin
        if (accept) begin
          st_d       = Q_RUN;
          op_d       = op_e'(cmd_op);
          wsh_d      = cmd_data;
          bit_d      = '0;
          busy_d     = 1'b1;
          slot_start = 1'b1;
          slot_kind  = kind_of(op_e'(cmd_op), cmd_data[0]);
        end
      end
      Q_RUN: begin
        if (slot_done) begin
          if (more) begin
            slot_start = 1'b1;
            slot_kind  = kind_of(op_q, wsh_q[1]);
            wsh_d      = wsh_q >> 1;
            bit_d      = bit_q + 1'b1;
            if ((bit_q == 3'd6) && (op_q == OP_WBYTE) && (dur_q != '0))
              pu_on_d = 1'b1;
          end else if (pu_on_q) begin
            st_d   = Q_HOLD;
            hold_d = '0;
          end else begin
            st_d   = Q_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end
      end
      Q_HOLD: begin
        if (tick) begin
          if (hold_q == dur_q - 1'b1) begin
            st_d    = Q_IDLE;
            busy_d  = 1'b0;
            done_d  = 1'b1;
            pu_on_d = 1'b0;
            dur_d   = '0;
            hold_d  = '0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
      end
      default: st_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= Q_IDLE;
      op_q    <= OP_RESET;
      wsh_q   <= '0;
      bit_q   <= '0;
      dur_q   <= '0;
      hold_q  <= '0;
      pu_on_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rbit_q  <= 1'b1;
      rbyte_q <= '0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      wsh_q   <= wsh_d;
      bit_q   <= bit_d;
      dur_q   <= dur_d;
      hold_q  <= hold_d;
      pu_on_q <= pu_on_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      rbit_q  <= rbit_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign rsp_bit   = rbit_q;
  assign rsp_byte  = rbyte_q;
  assign strong_pu = pu_on_q & ~drive_low;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_hold_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == Q_HOLD) |-> !drive_low);
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int DELAY_SCALE  = 1,
  parameter int PUD_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             pu_arm,
  input  logic [PUD_W-1:0] pu_dur,
  output logic             busy,
  output logic             done,
  output logic             rsp_bit,
  output logic [7:0]       rsp_byte,
  input  logic             line_in,
  output logic             drive_low,
  output logic             strong_pu
);
  localparam int DIV = TICKS_PER_US * DELAY_SCALE;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic [1:0] sync_q;
  logic       tick, tick_clr;
  logic       slot_start, slot_done, sample_vld, sample_bit;
  slot_kind_e slot_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sync_q <= 2'b11;
    else            sync_q <= {sync_q[0], line_in};
  end

  owm_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (tick_clr),
    .run   (busy),
    .tick  (tick)
  );

  owm_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .start      (slot_start),
    .kind       (slot_kind),
    .line_s     (sync_q[1]),
    .drive_low  (drive_low),
    .sample_vld (sample_vld),
    .sample_bit (sample_bit),
    .done       (slot_done)
  );

  owm_seq #(.PUD_W(PUD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .pu_arm     (pu_arm),
    .pu_dur     (pu_dur),
    .slot_done  (slot_done),
    .sample_vld (sample_vld),
    .sample_bit (sample_bit),
    .drive_low  (drive_low),
    .slot_start (slot_start),
    .slot_kind  (slot_kind),
    .tick_clr   (tick_clr),
    .busy       (busy),
    .done       (done),
    .rsp_bit    (rsp_bit),
    .rsp_byte   (rsp_byte),
    .strong_pu  (strong_pu)
  );

  // The bus is never pulled unless a command is running.
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !drive_low);

  p_pu_in_command_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    strong_pu |-> busy);
endmodule

// File: tb/onewire_master_bench.sv
`timescale 1ns/1ps
module onewire_master_bench;
  localparam int TPU = 2;
  localparam int SC  = 2;
  localparam int D   = TPU * SC;

  localparam logic [2:0] C_RST = 3'd0, C_WB = 3'd1, C_RB = 3'd2, C_WY = 3'd3, C_RY = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        pu_arm;
  logic [15:0] pu_dur;
  logic        busy, done, rsp_bit, drive_low, strong_pu;
  logic [7:0]  rsp_byte;
  logic        line_in;

  logic       slave_pull = 1'b0;
  logic       sl_rd = 1'b0, sl_present = 1'b0, dl_prev = 1'b0;
  logic [7:0] sl_bits = 8'hFF;
  int         t_in_slot = 0, slot_no = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  int m_lows[16];
  int m_nlow, m_busy, m_pu, m_ovl;
  bit m_timeout;

  always #2 clk = ~clk;

  assign line_in = ~(drive_low | slave_pull);

  onewire_master #(.TICKS_PER_US(TPU), .DELAY_SCALE(SC), .PUD_W(16)) u_onewire_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .pu_arm(pu_arm), .pu_dur(pu_dur), .busy(busy), .done(done), .rsp_bit(rsp_bit),
    .rsp_byte(rsp_byte), .line_in(line_in), .drive_low(drive_low), .strong_pu(strong_pu)
  );

  // Device model: answers in narrow windows around the expected sample points.
  always @(negedge clk) begin
    if (drive_low && !dl_prev) begin
      t_in_slot = 0;
      slot_no   = slot_no + 1;
    end else begin
      t_in_slot = t_in_slot + 1;
    end
    dl_prev = drive_low;
    slave_pull = (sl_rd && t_in_slot >= 13*D && t_in_slot < 16*D && slot_no > 0 &&
                  !sl_bits[3'(slot_no - 1)]) ||
                 (sl_present && t_in_slot >= 560*D && t_in_slot < 580*D);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_nlow(input logic [2:0] op);
    return (op == C_WY || op == C_RY) ? 8 : 1;
  endfunction

  function automatic int exp_low(input logic [2:0] op, input logic [7:0] d, input int i);
    if (op == C_RST) return 500*D;
    if (op == C_RB || op == C_RY) return 6*D;
    return d[i] ? 6*D : 60*D;
  endfunction

  function automatic int exp_busy(input logic [2:0] op, input int hold);
    if (op == C_RST) return 1000*D;
    if (op == C_WY || op == C_RY) return 560*D + hold*D;
    return 70*D;
  endfunction

  task automatic arm(input int dur);
    @(negedge clk);
    pu_arm = 1'b1;
    pu_dur = 16'(dur);
    @(negedge clk);
    pu_arm = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] data, input bit inject);
    int cur, cyc;
    slot_no = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_nlow = 0; m_busy = 0; m_pu = 0; m_ovl = 0; m_timeout = 1'b0;
    cur = 0; cyc = 0;
    while (!done) begin
      if (drive_low) cur++;
      else if (cur > 0) begin
        if (m_nlow < 16) m_lows[m_nlow] = cur;
        m_nlow++; cur = 0;
      end
      if (busy) m_busy++;
      if (strong_pu) m_pu++;
      if (strong_pu && drive_low) m_ovl++;
      if (inject && cyc == 20) begin cmd_valid = 1'b1; cmd_op = C_RST; cmd_data = 8'h00; end
      if (inject && cyc == 21) cmd_valid = 1'b0;
      if (cyc > 20000) begin m_timeout = 1'b1; break; end
      @(negedge clk);
      cyc++;
    end
    if (cur > 0) begin
      if (m_nlow < 16) m_lows[m_nlow] = cur;
      m_nlow++;
    end
    check(!m_timeout, "R9 command finished", cyc, 0);
    @(negedge clk);
    check(!done && !busy, "R9 done lasts one cycle", {30'd0, done, busy}, 0);
  endtask

  task automatic verify(input logic [2:0] op, input logic [7:0] d, input int hold, input string req);
    check(m_nlow == exp_nlow(op), {req, " slot count"}, m_nlow, exp_nlow(op));
    for (int i = 0; i < exp_nlow(op) && i < m_nlow; i++)
      check(m_lows[i] == exp_low(op, d, i), {req, " R12 low time"}, m_lows[i], exp_low(op, d, i));
    check(m_busy == exp_busy(op, hold), {req, " R9 R12 busy time"}, m_busy, exp_busy(op, hold));
    check(m_ovl == 0, "R10 strong_pu with drive_low", m_ovl, 0);
    if (op == C_WY && hold > 0)
      check(m_pu == ((d[7] ? 64 : 10) + hold)*D, "R10 strong_pu time", m_pu, ((d[7] ? 64 : 10) + hold)*D);
    else
      check(m_pu == 0, "R11 no strong_pu", m_pu, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [7:0] b;
    int dur;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'd0; pu_arm = 1'b0; pu_dur = 16'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1
    check(!drive_low && !strong_pu && !busy && !done, "R1 reset state",
          {28'd0, drive_low, strong_pu, busy, done}, 0);

    // R5 presence and absence
    sl_present = 1'b1;
    run_cmd(C_RST, 8'h00, 1'b0);
    verify(C_RST, 8'h00, 0, "R5");
    check(rsp_bit == 1'b0, "R5 presence seen", rsp_bit, 0);
    sl_present = 1'b0;
    run_cmd(C_RST, 8'h00, 1'b0);
    check(rsp_bit == 1'b1, "R5 no device", rsp_bit, 1);

    // R2, R3
    run_cmd(C_WB, 8'h01, 1'b0);
    verify(C_WB, 8'h01, 0, "R2");
    run_cmd(C_WB, 8'hFE, 1'b0);
    verify(C_WB, 8'hFE, 0, "R3");

    // R4
    sl_rd = 1'b1;
    sl_bits = 8'h00;
    run_cmd(C_RB, 8'h00, 1'b0);
    verify(C_RB, 8'h00, 0, "R4");
    check(rsp_bit == 1'b0, "R4 device low", rsp_bit, 0);
    sl_bits = 8'hFF;
    run_cmd(C_RB, 8'h00, 1'b0);
    check(rsp_bit == 1'b1, "R4 line high", rsp_bit, 1);

    // R7
    sl_bits = 8'h3C;
    run_cmd(C_RY, 8'h00, 1'b0);
    verify(C_RY, 8'h00, 0, "R7");
    check(rsp_byte == 8'h3C, "R7 read byte", rsp_byte, 8'h3C);
    sl_rd = 1'b0;

    // R6
    run_cmd(C_WY, 8'hA5, 1'b0);
    verify(C_WY, 8'hA5, 0, "R6");

    // R8: command while busy ignored
    run_cmd(C_WB, 8'h01, 1'b1);
    verify(C_WB, 8'h01, 0, "R8 busy ignore");
    // R8: undefined opcodes ignored
    for (int op = 5; op < 8; op++) begin
      int act;
      act = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = 8'h00;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (busy || drive_low || done) act++;
        @(negedge clk);
      end
      check(act == 0, "R8 undefined opcode", act, 0);
    end

    // R10, R11 directed
    arm(5);
    run_cmd(C_RY, 8'h00, 1'b0);
    verify(C_RY, 8'h00, 0, "R11 read keeps request");
    run_cmd(C_WB, 8'h00, 1'b0);
    verify(C_WB, 8'h00, 0, "R11 bit keeps request");
    run_cmd(C_WY, 8'h80, 1'b0);
    verify(C_WY, 8'h80, 5, "R10 bit7 one");
    run_cmd(C_WY, 8'h80, 1'b0);
    verify(C_WY, 8'h80, 0, "R11 one shot");
    arm(9);
    run_cmd(C_WY, 8'h01, 1'b0);
    verify(C_WY, 8'h01, 9, "R10 bit7 zero");
    arm(7);
    arm(0);
    run_cmd(C_WY, 8'hFF, 1'b0);
    verify(C_WY, 8'hFF, 0, "R11 cancel");

    // Random mix
    for (int it = 0; it < 14; it++) begin
      b = 8'($urandom);
      case ($urandom % 4)
        0: begin
          dur = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 30);
          if (dur > 0) arm(dur);
          run_cmd(C_WY, b, 1'b0);
          verify(C_WY, b, dur, "R6 R10 random write");
        end
        1: begin
          sl_rd = 1'b1; sl_bits = b;
          run_cmd(C_RY, 8'h00, 1'b0);
          verify(C_RY, 8'h00, 0, "R7 random read");
          check(rsp_byte == b, "R7 random read value", rsp_byte, b);
          sl_rd = 1'b0;
        end
        2: begin
          run_cmd(C_WB, b, 1'b0);
          verify(C_WB, b, 0, b[0] ? "R2 random" : "R3 random");
        end
        default: begin
          sl_rd = 1'b1; sl_bits = b;
          run_cmd(C_RB, 8'h00, 1'b0);
          check(rsp_bit == b[0], "R4 random read", rsp_bit, b[0]);
          sl_rd = 1'b0;
        end
      endcase
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule